// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block gathers every reason a processor supervisor has for holding its processor in reset into one stretched reset. The reasons are: power-on, which is the block's own synchronous reset input; a supply-fault flag from an external comparator; a raw, active-low manual push-button; and a single-cycle timeout pulse from a watchdog. Any active cause asserts reset on the next clock edge. Reset then stays asserted for a programmable minimum time after the last cause goes away.

The push-button is first passed through a two-stage synchronizer. It is then qualified by a run of consecutive low samples, so switch bounce and short glitches are rejected. All lengths are counted in `tick` strobes from a slow timebase. With a 1 ms tick, the defaults give a 20 ms button qualification and a 250 ms hold. The two outputs are an active-high reset and its strict complement, an active-low reset. Each comes from its own register, so the pad drivers outside the block can be of either kind.

Top module: `supv_reset_stretch`

## Requirements
- R1: While `rst` is high, `rst_hi` is 1 and `rst_lo_n` is 0. After `rst` falls, with `tick` high on every clock, `rst_hi` stays 1 for exactly HOLD_TICKS clocks.
- R2: A supply fault sampled high at a clock edge drives `rst_hi` to 1 after that edge. Reset is held for HOLD_TICKS+1 clocks after the last edge at which the fault was sampled high (`tick` high every clock).
- R3: `button_n` passes two synchronizer flops and then increments a low-run counter once per tick. A low lasting fewer than DEB_TICKS clocks (`tick` high every clock) never asserts reset.
- R4: Any high sample of the synchronized button clears the low-run counter. Bounced lows of DEB_TICKS-1 clocks, each separated by a single high clock, therefore never produce a reset.
- R5: A low lasting L >= DEB_TICKS clocks raises `rst_hi` DEB_TICKS+2 clocks after the first low edge. Reset is held while the button stays low and falls HOLD_TICKS+4 clocks after the last low edge, so the hold counts from release.
- R6: A one-clock watchdog pulse produces a reset of exactly HOLD_TICKS+1 clocks.
- R7: A new cause arriving while the hold is counting keeps reset asserted and reloads the hold. Reset then ends HOLD_TICKS+1 clocks after the newest cause's last edge.
- R8: `rst_lo_n` is always the logical inverse of `rst_hi`.
- R9: The hold and debounce counters advance only on clocks with `tick` high. With `tick` low, a pending hold never expires and a button low never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; also the power-on cause |
| tick | input | 1 | Timebase strobe; one pulse per counting unit |
| supply_fault | input | 1 | Supply out of tolerance, from external comparator |
| button_n | input | 1 | Raw manual reset button, active low, idles high |
| wdog_timeout | input | 1 | Watchdog expiry pulse |
| rst_hi | output | 1 | Active-high stretched reset |
| rst_lo_n | output | 1 | Active-low stretched reset, complement of `rst_hi` |

## Verification
The hardest situations to reach from the ports are the exact debounce boundary and a cause arriving partway through a running hold. The boundary is a low of DEB_TICKS-1 clocks against one of DEB_TICKS clocks, each passing through two synchronizer stages. The stimulus drives button lows of precisely chosen clock lengths around the boundary, and trains of bounced lows separated by single high clocks. For the mid-hold case, a watchdog pulse lands a few clocks after a supply fault has cleared, and the bench measures how long reset stays high. Gating `tick` low shows that both the hold and the qualification freeze between strobes.

// File: rtl/supv_rst_pkg.sv
package supv_rst_pkg;

    // One bit per reset reason handled by the hold stage
    typedef struct packed {
        logic supply;
        logic button;
        logic watchdog;
    } cause_t;

    // Hold stage state
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_ACTIVE = 2'd1,
        HS_HOLD   = 2'd2
    } hold_st_e;

    function automatic logic cause_any(cause_t c);
        return c.supply | c.button | c.watchdog;
    endfunction

    function automatic int unsigned cnt_bits(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/supv_btn_sync.sv
module supv_btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh_q[0] <= 1'b1;
                else     sh_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh_q[g] <= 1'b1;
                else     sh_q[g] <= sh_q[g-1];
            end
        end
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce
    import supv_rst_pkg::*;
#(
    parameter int DEB_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_s_n,
    output logic pressed
);
    localparam int            DW      = cnt_bits(DEB_TICKS);
    localparam logic [DW-1:0] DEB_MAX = DW'(DEB_TICKS);

    logic [DW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || btn_s_n) begin
            low_cnt_q <= '0;
        end else if (tick && (low_cnt_q != DEB_MAX)) begin
            low_cnt_q <= low_cnt_q + DW'(1);
        end
    end

    assign pressed = (low_cnt_q == DEB_MAX);

    // R4: a high sample restarts the low run
    a_r4_high_restarts: assert property (@(posedge clk) disable iff (rst)
        btn_s_n |=> (low_cnt_q == '0));

    // R3: the run counter never passes the qualification length
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        low_cnt_q <= DEB_MAX);

    // R9: no tick, no progress
    a_r9_deb_frozen: assert property (@(posedge clk) disable iff (rst)
        (!tick && !btn_s_n) |=> $stable(low_cnt_q));
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
    import supv_rst_pkg::*;
#(
    parameter int HOLD_TICKS = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  cause_t cause,
    output logic   rst_hi,
    output logic   rst_lo_n
);
    localparam int            CW      = cnt_bits(HOLD_TICKS);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_TICKS);

    hold_st_e      st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hi_q, lo_n_q;
    logic          any_c;

    assign any_c = cause_any(cause);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (any_c) begin
            st_d  = HS_ACTIVE;
            cnt_d = HOLD_LD;
        end else if (st_q != HS_IDLE) begin
            if (cnt_q == '0) begin
                st_d = HS_IDLE;
            end else if (tick) begin
                cnt_d = cnt_q - CW'(1);
                st_d  = HS_HOLD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= HS_HOLD;
            cnt_q  <= HOLD_LD;
            hi_q   <= 1'b1;
            lo_n_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            hi_q   <= (st_d != HS_IDLE);
            lo_n_q <= (st_d == HS_IDLE);
        end
    end

    assign rst_hi   = hi_q;
    assign rst_lo_n = lo_n_q;

    // R2: any cause asserts reset on the next edge
    a_r2_cause_sets: assert property (@(posedge clk) disable iff (rst)
        any_c |=> rst_hi);

    // R7: a cause reloads the full hold
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        any_c |=> (cnt_q == HOLD_LD));

    // R8: the two output registers never agree
    a_r8_complement: assert property (@(posedge clk) disable iff (rst)
        rst_lo_n != rst_hi);

    // R1: reset stays while hold count remains
    a_r1_no_early_drop: assert property (@(posedge clk) disable iff (rst)
        (st_q != HS_IDLE && cnt_q != '0) |=> rst_hi);

    // R6: an exhausted hold with no cause releases reset
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (!any_c && st_q != HS_IDLE && cnt_q == '0) |=> !rst_hi);

    // R9: hold frozen between ticks
    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (!any_c && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/supv_reset_stretch.sv
module supv_reset_stretch
    import supv_rst_pkg::*;
#(
    parameter int DEB_TICKS   = 20,
    parameter int HOLD_TICKS  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic supply_fault,
    input  logic button_n,
    input  logic wdog_timeout,
    output logic rst_hi,
    output logic rst_lo_n
);
    logic   btn_s_n;
    logic   btn_pressed;
    cause_t cause;

    supv_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (button_n),
        .dout (btn_s_n)
    );

    supv_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .btn_s_n (btn_s_n),
        .pressed (btn_pressed)
    );

    always_comb begin
        cause.supply   = supply_fault;
        cause.button   = btn_pressed;
        cause.watchdog = wdog_timeout;
    end

    supv_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cause    (cause),
        .rst_hi   (rst_hi),
        .rst_lo_n (rst_lo_n)
    );
endmodule

// File: tb/sim_supv_reset_stretch.sv
module sim_supv_reset_stretch;
    localparam int DEB  = 4;
    localparam int HOLD = 12;
    localparam int NV   = 9;
    // vector: [9:8] kind (0 supply, 1 button, 2 watchdog), [7:0] length in clocks
    localparam logic [9:0] VEC [NV] = '{
        {2'd0, 8'd1}, {2'd0, 8'd5}, {2'd2, 8'd1}, {2'd1, 8'd3},
        {2'd1, 8'd4}, {2'd1, 8'd9}, {2'd1, 8'd1}, {2'd0, 8'd20},
        {2'd1, 8'd40}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic supply_fault = 1'b0;
    logic button_n = 1'b1;
    logic wdog_timeout = 1'b0;
    logic rst_hi, rst_lo_n;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    supv_reset_stretch #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .supply_fault(supply_fault),
        .button_n(button_n), .wdog_timeout(wdog_timeout),
        .rst_hi(rst_hi), .rst_lo_n(rst_lo_n)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_highs(int k, int l);
        if (k == 1) return (l >= DEB) ? (l + HOLD + 1 - DEB) : 0;
        return l + HOLD;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!rst_hi) break;
        end
    endtask

    task automatic run_cause(int kind, int len, output int highs, output int comp_err);
        highs = 0;
        comp_err = 0;
        for (int i = 0; i < len + HOLD + DEB + 20; i++) begin
            @(negedge clk);
            if (rst_hi) highs++;
            if (rst_lo_n !== ~rst_hi) comp_err++;
            supply_fault = (kind == 0 && i < len);
            button_n     = !(kind == 1 && i < len);
            wdog_timeout = (kind == 2 && i < len);
        end
    endtask

    initial begin
        int h, ce;
        // R1: reset state and power-on hold
        repeat (5) @(negedge clk);
        check("R1 rst_hi during reset", int'(rst_hi), 1);
        check("R8 rst_lo_n during reset", int'(rst_lo_n), 0);
        rst = 1'b0;
        h = 0;
        for (int i = 0; i < HOLD + 10; i++) begin
            @(negedge clk);
            if (rst_hi) h++;
        end
        check("R1 power-on hold clocks", h, HOLD);

        // table walk: R2, R3, R5, R6, R8
        for (int v = 0; v < NV; v++) begin
            int k, l;
            k = int'(VEC[v][9:8]);
            l = int'(VEC[v][7:0]);
            wait_idle();
            run_cause(k, l, h, ce);
            case (k)
                0: check("R2 supply fault hold", h, exp_highs(k, l));
                2: check("R6 watchdog hold", h, exp_highs(k, l));
                default: begin
                    if (l < DEB) check("R3 short button ignored", h, exp_highs(k, l));
                    else         check("R5 button hold from release", h, exp_highs(k, l));
                end
            endcase
            check("R8 complement over vector", ce, 0);
        end

        // R4: bounced lows never qualify
        wait_idle();
        h = 0;
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < DEB; i++) begin
                @(negedge clk);
                if (rst_hi) h++;
                button_n = (i == DEB - 1);
            end
        end
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (rst_hi) h++;
        end
        check("R4 bounced button no reset", h, 0);

        // R7: watchdog arrives during supply hold
        wait_idle();
        h = 0;
        for (int i = 0; i < HOLD + 30; i++) begin
            @(negedge clk);
            if (rst_hi) h++;
            supply_fault = (i < 3);
            wdog_timeout = (i == 8);
        end
        check("R7 reload on new cause", h, 8 + HOLD + 1);

        // R9: hold frozen without ticks
        wait_idle();
        tick = 1'b0;
        wdog_timeout = 1'b1;
        @(negedge clk);
        wdog_timeout = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 hold frozen without tick", int'(rst_hi), 1);
        tick = 1'b1;
        h = 0;
        for (int i = 0; i < HOLD + 10; i++) begin
            @(negedge clk);
            if (rst_hi) h++;
        end
        check("R9 hold resumes on ticks", h, HOLD);

        // R9: button cannot qualify without ticks
        wait_idle();
        tick = 1'b0;
        h = 0;
        for (int i = 0; i < 3 * DEB + 10; i++) begin
            @(negedge clk);
            if (rst_hi) h++;
            button_n = !(i < 3 * DEB);
        end
        check("R9 button frozen without tick", h, 0);
        tick = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule